// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave

This block is the slave side of a two-wire serial memory holding 128 bytes. The bus clock and data lines come in asynchronously. They are synchronized to the system clock, and START and STOP conditions are recognised from edges of the data line while the bus clock is high. The block answers only on the data line, and it does so through an open-drain style enable: when `sda_oe` is high the pad pulls the line low, and when it is low the line is released.

Each transfer opens with a single byte that carries a 7-bit word address and then a direction bit. There is no separate device-select byte. A write stores each following byte at the pointer. The pointer then steps only inside its aligned 4-byte page. A read streams bytes for as long as the master acknowledges them, and the pointer runs across the whole array. A STOP that ends a write containing data starts an internal write cycle. During that cycle the slave gives no acknowledge to any transfer, so the host can poll for completion by sending address bytes.

Top module: `twowire_mem_slave`

## Requirements
- R1: After reset `sda_oe` is low. While no START has been seen, clocked bytes get no acknowledge.
- R2: A falling data edge while the clock is high is a START, and it restarts address reception even in the middle of a byte. A rising data edge while the clock is high is a STOP: it returns the block to idle with the line released.
- R3: The first byte after a START is the word address, MSB first, in bits 7..1, followed by the direction bit in bit 0 (0 means write, 1 means read). When the slave is not busy it acknowledges this byte by holding `sda_oe` high through the 9th clock.
- R4: In a write, every data byte is stored at the pointer and acknowledged on its 9th clock.
- R5: After each stored byte, pointer bits 1..0 increment modulo 4 and bits 6..2 stay fixed. A fifth byte in the same transfer overwrites the first location written.
- R6: A read returns the byte at the pointer, MSB first. `sda_oe` changes only while the clock is low, after a falling edge.
- R7: When the master acknowledges with a low bit on the 9th clock, the next byte follows from the pointer plus one, computed modulo 128, so address 127 is followed by address 0.
- R8: When the master answers a read byte with a high bit, the slave releases the line and drives nothing more until the next START.
- R9: A STOP that ends a write containing at least one data byte starts a busy period lasting WR_CYCLES system clocks. During that period address bytes get no acknowledge and write data is discarded. Once it ends, acknowledges return.
- R10: A write transfer that holds only the address byte, followed by a STOP, starts no busy period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line as seen on the wire, asynchronous |
| sda_oe | output | 1 | High pulls the data line low; low releases it |

## Verification
The hardest situation to reach is one in which the busy window and the bus framing overlap. The test needs a write attempt that arrives while the internal cycle is still counting, and it must then show that the attempt changed nothing. To reach it, the bench starts a new transfer as soon as the STOP of a byte write has been sent. It checks that this address byte gets no acknowledge and clocks a data byte through anyway. It then polls until acknowledges return and reads the location back. A second awkward case is a START that arrives three bits into a byte. The bench forces this with a partial-byte clocking task followed by a repeated START.

// File: rtl/twowire_mem_slave.sv
module twowire_mem_slave #(
  parameter int ADDR_W    = 7,
  parameter int PAGE_W    = 2,
  parameter int WR_CYCLES = 400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int BW    = $clog2(WR_CYCLES + 1);
  localparam logic [PAGE_W-1:0] PG_ONE = 1;
  localparam logic [ADDR_W-1:0] AD_ONE = 1;

  typedef enum logic [2:0] {IDLE, ADDR, AACK, WBYTE, WACK, RBYTE, MACK, HOLD} st_t;

  logic [1:0] scl_sy, sda_sy;
  logic       scl_q, sda_q;
  logic       scl_s, sda_s;
  st_t        st;
  logic [3:0] cnt;
  logic [7:0] sh;
  logic [ADDR_W-1:0] ptr;
  logic       rw, more, wpend;
  logic [BW-1:0] busy;
  logic [7:0] mem [DEPTH];

  assign scl_s = scl_sy[1];
  assign sda_s = sda_sy[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= 2'b11; sda_sy <= 2'b11; scl_q <= 1'b1; sda_q <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_i}; sda_sy <= {sda_sy[0], sda_i};
      scl_q  <= scl_s;              sda_q  <= sda_s;
    end
  end

  wire start_c = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_c  = scl_s & scl_q & ~sda_q & sda_s;
  wire rise    = scl_s & ~scl_q;
  wire fall    = ~scl_s & scl_q;
  wire ev      = ~start_c & ~stop_c;

  wire [7:0] rd_byte = mem[ptr];
  wire       mem_we  = ev && fall && st == WBYTE && cnt == 4'd8;

  always_ff @(posedge clk) begin
    if (mem_we) mem[ptr] <= sh;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; cnt <= '0; sh <= '0; ptr <= '0; rw <= 1'b0;
      more <= 1'b0; wpend <= 1'b0; busy <= '0; sda_oe <= 1'b0;
    end else begin
      if (busy != '0) busy <= busy - 1'b1;
      if (start_c) begin
        st <= ADDR; cnt <= '0; sda_oe <= 1'b0;
      end else if (stop_c) begin
        st <= IDLE; sda_oe <= 1'b0;
        if (wpend) begin
          busy  <= BW'(WR_CYCLES);
          wpend <= 1'b0;
        end
      end else begin
        case (st)
          ADDR, WBYTE: begin
            if (rise && cnt != 4'd8) begin
              sh  <= {sh[6:0], sda_s};
              cnt <= cnt + 1'b1;
            end
            if (fall && cnt == 4'd8) begin
              if (st == ADDR) begin
                if (busy != '0) st <= HOLD;
                else begin
                  ptr <= sh[7:1]; rw <= sh[0]; sda_oe <= 1'b1; st <= AACK;
                end
              end else begin
                ptr    <= {ptr[ADDR_W-1:PAGE_W], ptr[PAGE_W-1:0] + PG_ONE};
                wpend  <= 1'b1;
                sda_oe <= 1'b1;
                st     <= WACK;
              end
            end
          end
          AACK, WACK: if (fall) begin
            cnt <= '0;
            if (st == AACK && rw) begin
              sh <= rd_byte; ptr <= ptr + AD_ONE; sda_oe <= ~rd_byte[7]; st <= RBYTE;
            end else begin
              sda_oe <= 1'b0; st <= WBYTE;
            end
          end
          RBYTE: if (fall) begin
            if (cnt == 4'd7) begin
              sda_oe <= 1'b0; cnt <= '0; st <= MACK;
            end else begin
              cnt <= cnt + 1'b1; sh <= {sh[6:0], 1'b0}; sda_oe <= ~sh[6];
            end
          end
          MACK: begin
            if (rise) more <= ~sda_s;
            if (fall) begin
              if (more) begin
                sh <= rd_byte; ptr <= ptr + AD_ONE; sda_oe <= ~rd_byte[7]; st <= RBYTE;
              end else st <= HOLD;
            end
          end
          default: ;
        endcase
      end
    end
  end

  a_r2_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
    stop_c |=> (!sda_oe && st == IDLE));
  a_r6_drive_on_low_clock: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe) && !$past(start_c) && !$past(stop_c)) |-> !scl_s);
  a_r5_page_step: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> (ptr[ADDR_W-1:PAGE_W] == $past(ptr[ADDR_W-1:PAGE_W]) &&
                ptr[PAGE_W-1:0] == $past(ptr[PAGE_W-1:0]) + PG_ONE));
  a_r7_read_step: assert property (@(posedge clk) disable iff (!rst_n)
    (ev && fall && st == MACK && more) |=> ptr == $past(ptr) + AD_ONE);
  a_r9_busy_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (ev && fall && st == ADDR && cnt == 4'd8 && busy != '0) |=> !sda_oe);
  a_r9_busy_counts: assert property (@(posedge clk) disable iff (!rst_n)
    (busy != '0) |=> busy == $past(busy) - 1'b1);
endmodule

// File: tb/tb_twowire_mem_slave.sv
module tb_twowire_mem_slave;
  localparam int H = 10;
  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1;
  logic sda_oe;
  wire  sda_bus = sda_m & ~sda_oe;
  int   tests = 0, fails = 0;
  bit   done = 1'b0;

  always #2.5 clk = ~clk;

  twowire_mem_slave dut (.clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_oe(sda_oe));

  localparam logic [14:0] VEC [8] = '{
    {7'h7E, 8'hA5}, {7'h7F, 8'h3C}, {7'h00, 8'h81}, {7'h01, 8'h5A},
    {7'h24, 8'hC3}, {7'h55, 8'h0F}, {7'h0A, 8'hF0}, {7'h6E, 8'h99}};

  task automatic wt(input int n); repeat (n) @(negedge clk); endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_bit(input logic b, output logic seen);
    sda_m = b; wt(H); scl = 1'b1; wt(H/2); seen = sda_bus; wt(H/2); scl = 1'b0;
  endtask

  task automatic bus_start;
    sda_m = 1'b1; wt(H); scl = 1'b1; wt(H); sda_m = 1'b0; wt(H); scl = 1'b0; wt(2);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; wt(H); scl = 1'b1; wt(H); sda_m = 1'b1; wt(H);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bus_bit(b[i], s);
    bus_bit(1'b1, s);
    ack = ~s;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin bus_bit(1'b1, s); d[i] = s; end
    bus_bit(~mack, s);
  endtask

  task automatic wr1(input logic [6:0] a, input logic [7:0] d, output logic ok);
    logic k1, k2;
    bus_start; send_byte({a, 1'b0}, k1); send_byte(d, k2); bus_stop;
    ok = k1 & k2;
  endtask

  task automatic rd1(input logic [6:0] a, output logic [7:0] d);
    logic k;
    bus_start; send_byte({a, 1'b1}, k); recv_byte(1'b0, d); bus_stop;
  endtask

  task automatic poll(output logic ack);
    bus_start; send_byte(8'h00, ack); bus_stop;
  endtask

  task automatic wait_ready;
    logic a;
    for (int i = 0; i < 30; i++) begin poll(a); if (a) break; end
  endtask

  initial begin
    logic a, ok, s;
    logic [7:0] d;
    int rel;
    wt(4);
    chk("R1 reset oe", {7'h0, sda_oe}, 8'h00);
    rst_n = 1'b1; wt(4);
    sda_m = 1'b1; scl = 1'b0; wt(H);
    send_byte({7'h00, 1'b0}, a);
    chk("R1 no ack before START", {7'h0, a}, 8'h00);

    foreach (VEC[i]) begin
      wr1(VEC[i][14:8], VEC[i][7:0], ok);
      chk("R3/R4 write acks", {7'h0, ok}, 8'h01);
      wait_ready;
      rd1(VEC[i][14:8], d);
      chk("R4/R6 byte read back", d, VEC[i][7:0]);
    end

    bus_start; send_byte({7'h7E, 1'b1}, a);
    chk("R3 read addr ack", {7'h0, a}, 8'h01);
    recv_byte(1'b1, d); chk("R7 seq 7E", d, 8'hA5);
    recv_byte(1'b1, d); chk("R7 seq 7F", d, 8'h3C);
    recv_byte(1'b1, d); chk("R7 wrap to 00", d, 8'h81);
    recv_byte(1'b0, d); chk("R7 seq 01", d, 8'h5A);
    rel = 0;
    for (int i = 0; i < 9; i++) begin bus_bit(1'b1, s); if (!s) rel++; end
    chk("R8 silent after nack", 8'(rel), 8'h00);
    bus_stop;

    bus_start;
    for (int i = 0; i < 3; i++) bus_bit(i[0], s);
    bus_start; send_byte({7'h24, 1'b1}, a);
    chk("R2 restart mid-byte ack", {7'h0, a}, 8'h01);
    recv_byte(1'b0, d); chk("R2 restart read", d, 8'hC3);
    bus_stop;

    bus_start; for (int i = 0; i < 4; i++) bus_bit(1'b0, s); bus_stop;
    chk("R2 stop mid-byte releases", {7'h0, sda_oe}, 8'h00);

    bus_start; send_byte({7'h21, 1'b0}, ok);
    send_byte(8'h11, a); ok &= a; send_byte(8'h22, a); ok &= a;
    send_byte(8'h33, a); ok &= a; send_byte(8'h44, a); ok &= a;
    send_byte(8'h55, a); ok &= a;
    bus_stop;
    chk("R4 page write acks", {7'h0, ok}, 8'h01);
    poll(a);
    chk("R9 busy right after stop", {7'h0, a}, 8'h00);
    wait_ready;
    bus_start; send_byte({7'h20, 1'b1}, a);
    recv_byte(1'b1, d); chk("R5 wrapped 4th byte", d, 8'h44);
    recv_byte(1'b1, d); chk("R5 overwritten by 5th", d, 8'h55);
    recv_byte(1'b1, d); chk("R5 slot 22", d, 8'h22);
    recv_byte(1'b1, d); chk("R5 slot 23", d, 8'h33);
    recv_byte(1'b0, d); chk("R5 next page untouched", d, 8'hC3);
    bus_stop;

    wr1(7'h55, 8'h77, ok);
    bus_start; send_byte({7'h55, 1'b0}, a);
    chk("R9 no ack while busy", {7'h0, a}, 8'h00);
    send_byte(8'h11, a); bus_stop;
    wait_ready;
    rd1(7'h55, d);
    chk("R9 busy write discarded", d, 8'h77);
    poll(a);
    chk("R10 address-only write no busy", {7'h0, a}, 8'h01);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    done = 1'b1;
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: got hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule